// File: doc/BRIEF.md
# System Clock Source Selector with Timer Tick Prescaler

This block decides which oscillator drives the system clock: an external crystal running at 32 MHz or an internal RC oscillator running at 16 MHz. Software writes a one-byte control word. The block then asks the oscillators to power up and watches their stable flags. It moves the active source only when the requested oscillator is ready. A move to the crystal also needs a fixed settle window after the crystal's stable flag. The status byte always shows which clock is really in use.

The block also produces a one-cycle tick enable that several peripheral timers share. A 3-bit code sets the tick rate, from 32 MHz down to 250 kHz in halving steps. The divider adapts to the active source so that a code gives the same tick period in time on either clock, and the tick never runs faster than the system clock. A separate select bit for the slow 32 kHz oscillator may only be changed while the RC oscillator drives the system. That bit is forced back to RC when the chip wakes from a deep power mode.

Top module: `sysclk_tick_ctrl`

## Requirements
- R1: After reset `status_rd` is 0xC9. Its layout is: bit 7 = slow oscillator select (1 = RC), bit 6 = requested system source (1 = RC), bits 5:3 = tick code, bits 2:1 always read 0, bit 0 = active source (1 = RC / 16 MHz, 0 = crystal / 32 MHz). Bit 0 cannot be written.
- R2: Bits 6 and 5:3 take the written value at the write edge, whatever the state. Writing bit 6 alone does not change bit 0.
- R3: `xtal_pwr_req` is 1 while the crystal is requested or active. `rc_pwr_req` is 1 while the RC oscillator is requested or active. Both follow one cycle after the register state.
- R4: When the crystal is requested and the RC oscillator is active, bit 0 falls at the SETTLE_CYC-th consecutive clock edge (default 1024) that sees `xtal_stable` high and no write. A write, or a low stable flag, restarts the count.
- R5: When the RC oscillator is requested and the crystal is active, bit 0 rises at the first edge that sees `rc_stable` high. It never rises while `rc_stable` is low.
- R6: A write changes bit 7 only if bit 0 is 1 (RC active). Otherwise bit 7 keeps its value.
- R7: On the crystal, the tick period is 2^code system cycles (code 0 gives a tick every cycle, code 7 gives one every 128 cycles).
- R8: On the RC oscillator, the tick period is 2^(code-1) cycles, with code 0 clamped to 1 cycle, so that the tick never exceeds the system clock.
- R9: A `deep_wake` pulse sets bit 7 to 1 and leaves bits 6:0 unchanged.
- R10: When the period is longer than one cycle, `tick_en` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| xtal_stable | input | 1 | Crystal oscillator is running and stable |
| rc_stable | input | 1 | RC oscillator is running and stable |
| deep_wake | input | 1 | One-cycle pulse on return from a deep power mode |
| status_rd | output | 8 | Read-back of the control and status byte |
| slow_osc_rc | output | 1 | Slow oscillator select (1 = RC) |
| sys_src_rc | output | 1 | Active system source (1 = RC) |
| xtal_pwr_req | output | 1 | Crystal power-up request |
| rc_pwr_req | output | 1 | RC power-up request |
| tick_en | output | 1 | Timer tick enable pulse |

## Verification
The switch is tested in both directions. The move to the crystal is first held back with the stable flag low. It is then interrupted by a mid-window write, and the bench checks that the active source holds one edge before the restarted window ends and changes at the edge that ends it. The move back to the RC oscillator is tried with its stable flag low and then high. This separates "waits for stable" from "switches at once". Tick periods are measured for the shortest, middle and longest codes on each source. The measurements tell the scaled RC divider and its code-0 clamp apart from the plain crystal divider. Slow-select writes are tried on both sources and around a wake pulse, to show the guard and the forced restore.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int unsigned CODE_W = 3;

  // bit positions in the control/status byte (software decodes them)
  localparam int unsigned BIT_SLOW = 7;
  localparam int unsigned BIT_SYS  = 6;
  localparam int unsigned BIT_TLO  = 3;
  localparam int unsigned BIT_ACT  = 0;

  typedef struct packed {
    logic              slow_rc;
    logic              sys_rc;
    logic [CODE_W-1:0] tick_code;
  } clk_cfg_t;

  typedef enum logic [1:0] {
    SW_IDLE      = 2'd0,
    SW_WAIT_XTAL = 2'd1,
    SW_WAIT_RC   = 2'd2
  } sw_state_t;
endpackage

// File: rtl/cks_regfile.sv
module cks_regfile
  import clk_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       active_rc,
  input  logic       deep_wake,
  output clk_cfg_t   cfg
);
  clk_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.slow_rc   <= 1'b1;
      cfg_q.sys_rc    <= 1'b1;
      cfg_q.tick_code <= CODE_W'(1);
    end else begin
      if (wr_en) begin
        cfg_q.sys_rc    <= wr_data[BIT_SYS];
        cfg_q.tick_code <= wr_data[BIT_TLO +: CODE_W];
      end
      // wake restore wins over a concurrent guarded write
      if (deep_wake) begin
        cfg_q.slow_rc <= 1'b1;
      end else if (wr_en && active_rc) begin
        cfg_q.slow_rc <= wr_data[BIT_SLOW];
      end
    end
  end

  assign cfg = cfg_q;

  // R6 / R9: slow select only moves under RC or on wake
  a_r6_slow_guard: assert property (@(posedge clk) disable iff (rst)
    ($rose(cfg_q.slow_rc) || $fell(cfg_q.slow_rc)) |->
      ($past(active_rc) || $past(deep_wake)));

  a_r9_wake_restore: assert property (@(posedge clk) disable iff (rst)
    $past(deep_wake) |-> cfg_q.slow_rc);
endmodule

// File: rtl/cks_src_switch.sv
module cks_src_switch
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1024
)(
  input  logic clk,
  input  logic rst,
  input  logic req_rc,
  input  logic wr_en,
  input  logic xtal_stable,
  input  logic rc_stable,
  output logic active_rc
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  sw_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SW_IDLE;
      cnt_q   <= '0;
      act_q   <= 1'b1;
    end else if (req_rc == act_q) begin
      state_q <= SW_IDLE;
      cnt_q   <= '0;
    end else if (!req_rc) begin
      state_q <= SW_WAIT_XTAL;
      if (wr_en || !xtal_stable) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      state_q <= SW_WAIT_RC;
      cnt_q   <= '0;
      if (rc_stable) act_q <= 1'b1;
    end
  end

  assign active_rc = act_q;

  // R4: crystal only taken with stable flag seen and no write at that edge
  a_r4_xtal_gate: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(xtal_stable) && !$past(wr_en) && !$past(req_rc)));

  // R5: RC only taken with its stable flag seen
  a_r5_rc_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> ($past(rc_stable) && $past(req_rc)));
endmodule

// File: rtl/cks_tick_gen.sv
module cks_tick_gen
  import clk_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              on_rc,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] shift_w;
  logic [CNT_W-1:0]  reload_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick_q;

  // RC runs at half rate: one step less division, floor at every cycle
  always_comb begin
    if (on_rc) shift_w = (code == '0) ? '0 : code - 1'b1;
    else       shift_w = code;
    reload_w = CNT_W'((1 << shift_w) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= reload_w;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R10: back-to-back ticks only when the divider was at one cycle
  a_r10_single_tick: assert property (@(posedge clk) disable iff (rst)
    (tick_q && $past(tick_q)) |-> ($past(shift_w, 2) == '0));
endmodule

// File: rtl/sysclk_tick_ctrl.sv
module sysclk_tick_ctrl
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1024
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       xtal_stable,
  input  logic       rc_stable,
  input  logic       deep_wake,
  output logic [7:0] status_rd,
  output logic       slow_osc_rc,
  output logic       sys_src_rc,
  output logic       xtal_pwr_req,
  output logic       rc_pwr_req,
  output logic       tick_en
);
  clk_cfg_t cfg;
  logic     act_rc;
  logic     xpwr_q, rpwr_q;

  cks_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .active_rc (act_rc),
    .deep_wake (deep_wake),
    .cfg       (cfg)
  );

  cks_src_switch #(.SETTLE_CYC(SETTLE_CYC)) u_switch (
    .clk         (clk),
    .rst         (rst),
    .req_rc      (cfg.sys_rc),
    .wr_en       (wr_en),
    .xtal_stable (xtal_stable),
    .rc_stable   (rc_stable),
    .active_rc   (act_rc)
  );

  cks_tick_gen u_tick (
    .clk   (clk),
    .rst   (rst),
    .on_rc (act_rc),
    .code  (cfg.tick_code),
    .tick  (tick_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xpwr_q <= 1'b0;
      rpwr_q <= 1'b1;
    end else begin
      xpwr_q <= !cfg.sys_rc || !act_rc;
      rpwr_q <= cfg.sys_rc || act_rc;
    end
  end

  assign xtal_pwr_req = xpwr_q;
  assign rc_pwr_req   = rpwr_q;
  assign slow_osc_rc  = cfg.slow_rc;
  assign sys_src_rc   = act_rc;

  always_comb begin
    status_rd                       = '0;
    status_rd[BIT_SLOW]             = cfg.slow_rc;
    status_rd[BIT_SYS]              = cfg.sys_rc;
    status_rd[BIT_TLO +: CODE_W]    = cfg.tick_code;
    status_rd[BIT_ACT]              = act_rc;
  end

  // R3: the oscillator in use is always kept powered
  a_r3_xtal_powered: assert property (@(posedge clk) disable iff (rst)
    (!act_rc && !$past(act_rc)) |-> xpwr_q);
  a_r3_rc_powered: assert property (@(posedge clk) disable iff (rst)
    (act_rc && $past(act_rc)) |-> rpwr_q);
endmodule

// File: tb/test_sysclk_tick_ctrl.sv
module test_sysclk_tick_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       xtal_stable = 1'b0;
  logic       rc_stable = 1'b1;
  logic       deep_wake = 1'b0;
  logic [7:0] status_rd;
  logic       slow_osc_rc, sys_src_rc, xtal_pwr_req, rc_pwr_req, tick_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysclk_tick_ctrl i_sysclk_tick_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .xtal_stable(xtal_stable), .rc_stable(rc_stable), .deep_wake(deep_wake),
    .status_rd(status_rd), .slow_osc_rc(slow_osc_rc), .sys_src_rc(sys_src_rc),
    .xtal_pwr_req(xtal_pwr_req), .rc_pwr_req(rc_pwr_req), .tick_en(tick_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    chk(status_rd === exp, tag, status_rd, exp);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard: expected tick gaps
  int    exp_q[$];
  string tag_q[$];
  longint cyc = 0;
  longint last_tick = 0;
  bit have_last = 0;
  bit mon_on = 0;
  bit arm_req = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (arm_req) begin
      arm_req   = 0;
      have_last = 0;
      mon_on    = 1;
    end
    if (tick_en) begin
      if (mon_on && have_last && exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(cyc - last_tick) == e, t, int'(cyc - last_tick), e);
        if (exp_q.size() == 0) mon_on = 0;
      end
      last_tick = cyc;
      have_last = 1;
    end
  end

  task automatic tick_period(input int p, input string tag);
    idle(300);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(p);
      tag_q.push_back((p > 1) ? {tag, "/R10"} : tag);
    end
    arm_req = 1;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk_stat("R1 reset status", 8'hC9);
    chk(rc_pwr_req === 1'b1 && xtal_pwr_req === 1'b0, "R3 reset power", {rc_pwr_req, xtal_pwr_req}, 2'b10);

    // R8 RC ticks: code1 -> 1, code0 clamp -> 1, code3 -> 4, code7 -> 64
    tick_period(1, "R8 rc code1");
    wr(8'hC0); tick_period(1, "R8 rc code0 clamp");
    wr(8'hD8); tick_period(4, "R8 rc code3");
    wr(8'hF8); tick_period(64, "R8 rc code7");

    // R1 reserved bits and read-only bit 0
    wr(8'hFF); chk_stat("R1 reserved read zero", 8'hF9);
    // R6 slow select accepted on RC
    wr(8'h49); chk_stat("R6 slow select on rc", 8'h49);
    chk(slow_osc_rc === 1'b0, "R6 slow pin", slow_osc_rc, 0);
    // R9 wake restore
    @(negedge clk); deep_wake = 1'b1; @(negedge clk); deep_wake = 1'b0;
    chk_stat("R9 wake restores slow select", 8'hC9);
    wr(8'h49);

    // R2 request crystal, not yet stable
    wr(8'h09); chk_stat("R2 request keeps source", 8'h09);
    idle(2000);
    chk(status_rd[0] === 1'b1, "R4 no switch while unstable", status_rd[0], 1);
    chk(xtal_pwr_req === 1'b1 && rc_pwr_req === 1'b1, "R3 both powered", {xtal_pwr_req, rc_pwr_req}, 2'b11);

    // R4 settle window with restart by a write
    xtal_stable = 1'b1;
    idle(500);
    wr(8'h09);
    idle(1023);
    chk(sys_src_rc === 1'b1, "R4 held one edge early", sys_src_rc, 1);
    idle(1);
    chk_stat("R4 switched at window end", 8'h08);
    idle(3);
    chk(rc_pwr_req === 1'b0 && xtal_pwr_req === 1'b1, "R3 rc released", {xtal_pwr_req, rc_pwr_req}, 2'b10);

    // R6 slow select ignored on crystal
    wr(8'h88); chk_stat("R6 ignored on crystal", 8'h08);

    // R7 crystal ticks
    wr(8'h00); tick_period(1, "R7 xtal code0");
    tick_period(1, "R7 xtal code0 again");
    wr(8'h08); tick_period(2, "R7 xtal code1");
    wr(8'h20); tick_period(16, "R7 xtal code4");
    wr(8'h38); tick_period(128, "R7 xtal code7");

    // R5 back to RC, first without stable flag
    rc_stable = 1'b0;
    wr(8'h58);
    idle(10);
    chk_stat("R5 waits for rc stable", 8'h58);
    chk(rc_pwr_req === 1'b1, "R3 rc power requested", rc_pwr_req, 1);
    rc_stable = 1'b1;
    idle(1);
    chk_stat("R5 rc active next edge", 8'h59);
    tick_period(4, "R8 rc code3 after switch");

    @(negedge clk); deep_wake = 1'b1; @(negedge clk); deep_wake = 1'b0;
    chk_stat("R9 wake keeps other bits", 8'hD9);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule